// File: doc/BRIEF.md
# Octal SPI Boot Read Sequencer

This block fetches the boot image from an octal serial flash. It uses one fixed transfer shape: single-line command, single-line address, eight-line data, all at single data rate. A one-cycle `start` pulse and a byte count begin a transfer. The sequencer then does the following in order:

- It pulls the strap-selected chip select low.
- It shifts the read opcode 0x8B and a 24-bit zero address out on data line 0.
- It idles through a fixed number of dummy serial clocks.
- It captures one byte per serial clock from all eight lines.

The serial clock is the system clock divided by the even parameter `CLK_DIV`. A divider of 4 from a 133 MHz system clock gives about 33 MHz.

Captured bytes leave on a valid/ready stream. A byte is presented with `out_valid` high and stays unchanged until the cycle in which `out_ready` is also high. While a byte waits, the sequencer holds the serial clock low at the start of the next period. The flash therefore never shifts out a byte that has nowhere to go, and back-pressure of any length is safe. When the last byte has been taken, the chip select is released after a hold period and `done` pulses for one cycle.

Top module: `ospi_boot_reader`

## Requirements
- R1: Each serial clock period lasts `CLK_DIV` system cycles: low for the first half, high for the second. During the command/address phase, `dq_oe[0]` is high and `dq_o[0]` carries 0x8B followed by 24 zero bits, most significant bit first. Each bit changes only at the start of a period, where the serial clock falls.
- R2: After the last address bit, exactly 8 serial clock periods follow with all `dq_oe` bits low.
- R3: In each data period, `dq_i` is sampled when the serial clock rises. Bit 7 of `dq_i` is the MSB, and the byte appears on `out_data` with `out_valid` high.
- R4: While `out_valid` is high and `out_ready` is low, `out_data` stays stable. No new serial clock rising edge occurs until that byte has been accepted.
- R5: `cs_strap` sampled at start selects the chip select: 0 drives `cs_n[0]` low, 1 drives `cs_n[1]` low. The other chip select stays high, and both are never low together.
- R6: Chip select is low for one full serial period before the first rising edge. It stays low for one full serial period after the last falling edge and after the last byte is accepted.
- R7: At the end of a transfer, `done` is high for exactly one cycle, with both chip selects high and `busy` low.
- R8: A start with a byte count of zero raises `done` on the next cycle without asserting any chip select.
- R9: A start pulse while `busy` is high has no effect on the transfer in progress.
- R10: After reset, both chip selects are high, the serial clock is low, all output enables are low, and `out_valid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transfer request, ignored while busy |
| byte_count | input | CNT_W | Number of bytes to read, sampled with start |
| cs_strap | input | 1 | Chip-select choice, sampled with start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 2 | Active-low chip selects |
| dq_o | output | 8 | Data line output values |
| dq_oe | output | 8 | Data line output enables |
| dq_i | input | 8 | Data line input values |
| out_data | output | 8 | Read byte |
| out_valid | output | 1 | Read byte is valid |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The assertions rely on the following input behaviour:
- `dq_i` is steady across the edge where the serial clock rises during data periods.
- `start` is a single-cycle pulse.
- `out_ready` may change freely on any cycle.

The stimulus changes `dq_i` only at the start of each data period. It drives `out_ready` with an always-ready pattern, a random pattern and a pattern with long stalls, so that the assertions on held bytes and on the clock pause are exercised. A start pulse is also injected in the middle of a transfer, and the behavioural model expects the transfer to continue untouched.

// File: rtl/ospi_boot_pkg.sv
package ospi_boot_pkg;
  localparam int CMD_BITS   = 8;
  localparam int ADDR_BITS  = 24;
  localparam int FRAME_BITS = CMD_BITS + ADDR_BITS;
  localparam logic [CMD_BITS-1:0] READ_OPCODE = 8'h8B;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_DUMMY,
    ST_DATA,
    ST_HOLD
  } seq_state_t;
endpackage

// File: rtl/ospi_phase_gen.sv
module ospi_phase_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic [$clog2(DIV)-1:0] ph,
  output logic wrap,
  output logic rise
);
  localparam int PH_W = $clog2(DIV);
  localparam int HALF = DIV / 2;

  assign wrap = run && !hold && (ph == PH_W'(DIV - 1));
  assign rise = run && !hold && (ph == PH_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph <= '0;
    else if (!run)   ph <= '0;
    else if (hold)   ph <= ph;
    else if (wrap)   ph <= '0;
    else             ph <= ph + 1'b1;
  end
endmodule

// File: rtl/ospi_cmd_shifter.sv
module ospi_cmd_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/ospi_byte_out.sv
module ospi_byte_out #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [LANES-1:0] lanes_in,
  input  logic             ready,
  output logic [LANES-1:0] data,
  output logic             valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      if (cap) begin
        valid <= 1'b1;
        data  <= lanes_in;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ospi_boot_reader.sv
module ospi_boot_reader
  import ospi_boot_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int DUMMY_CLKS = 8,
  parameter int CNT_W      = 16,
  parameter int LANES      = 8,
  parameter logic [ADDR_BITS-1:0] BOOT_ADDR = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             cs_strap,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic [1:0]       cs_n,
  output logic [LANES-1:0] dq_o,
  output logic [LANES-1:0] dq_oe,
  input  logic [LANES-1:0] dq_i,
  output logic [LANES-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  localparam int PH_W  = $clog2(CLK_DIV);
  localparam int HALF  = CLK_DIV / 2;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int DUM_W = $clog2(DUMMY_CLKS + 1);

  seq_state_t        state;
  logic [PH_W-1:0]   ph;
  logic              wrap, rise, stall, run;
  logic [BIT_W-1:0]  bit_idx;
  logic [DUM_W-1:0]  dum_idx;
  logic [CNT_W-1:0]  remain;
  logic              sel;
  logic              load_frame, frame_msb;

  assign run        = (state != ST_IDLE);
  assign stall      = ((state == ST_DATA) || (state == ST_HOLD)) &&
                      (ph == '0) && out_valid && !out_ready;
  assign load_frame = (state == ST_IDLE) && start && (byte_count != '0);

  ospi_phase_gen #(.DIV(CLK_DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(stall),
    .ph(ph), .wrap(wrap), .rise(rise)
  );

  ospi_cmd_shifter #(.W(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_frame),
    .load_val({READ_OPCODE, BOOT_ADDR}),
    .shift(wrap && (state == ST_CMD)), .msb(frame_msb)
  );

  ospi_byte_out #(.LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .cap(rise && (state == ST_DATA)),
    .lanes_in(dq_i), .ready(out_ready), .data(out_data), .valid(out_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      bit_idx <= '0;
      dum_idx <= '0;
      remain  <= '0;
      sel     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          if (byte_count == '0) begin
            done <= 1'b1;
          end else begin
            state  <= ST_SETUP;
            remain <= byte_count;
            sel    <= cs_strap;
          end
        end
        ST_SETUP: if (wrap) begin
          state   <= ST_CMD;
          bit_idx <= '0;
        end
        ST_CMD: if (wrap) begin
          if (bit_idx == BIT_W'(FRAME_BITS - 1)) begin
            state   <= ST_DUMMY;
            dum_idx <= '0;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_DUMMY: if (wrap) begin
          if (dum_idx == DUM_W'(DUMMY_CLKS - 1)) state <= ST_DATA;
          else                                   dum_idx <= dum_idx + 1'b1;
        end
        ST_DATA: if (wrap) begin
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= ST_HOLD;
        end
        ST_HOLD: if (wrap) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = run;
  assign sclk = ((state == ST_CMD) || (state == ST_DUMMY) || (state == ST_DATA)) &&
                (ph >= PH_W'(HALF));

  always_comb begin
    cs_n = 2'b11;
    if (run) cs_n[sel] = 1'b0;
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_cmd_lane
        assign dq_oe[g] = (state == ST_CMD);
        assign dq_o[g]  = (state == ST_CMD) && frame_msb;
      end else begin : g_rx_lane
        assign dq_oe[g] = 1'b0;
        assign dq_o[g]  = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/ospi_boot_reader_chk.sv
module ospi_boot_reader_chk #(
  parameter int CNT_W = 16,
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] byte_count,
  input logic             busy,
  input logic             done,
  input logic             sclk,
  input logic [1:0]       cs_n,
  input logic [LANES-1:0] dq_oe,
  input logic [LANES-1:0] out_data,
  input logic             out_valid,
  input logic             out_ready
);
  p_one_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n != 2'b00);

  p_cs_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 2'b11) && $past(cs_n != 2'b11) |-> $stable(cs_n));

  p_drive_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> (cs_n != 2'b11) && (dq_oe[LANES-1:1] == '0));

  p_hold_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(!out_valid || out_ready));

  p_sclk_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> cs_n != 2'b11);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n == 2'b11) && !busy);

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && (byte_count == '0) |=> done && (cs_n == 2'b11));
endmodule

bind ospi_boot_reader ospi_boot_reader_chk #(.CNT_W(CNT_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
  .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n), .dq_oe(dq_oe),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/ospi_boot_reader_bench.sv
module ospi_boot_reader_bench;
  localparam int DIV   = 4;
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic             cs_strap = 1'b0;
  logic             busy, done, sclk;
  logic [1:0]       cs_n;
  logic [7:0]       dq_o, dq_oe, out_data;
  logic [7:0]       dq_i = 8'hFF;
  logic             out_valid;
  logic             out_ready = 1'b1;

  int   vectors = 0;
  int   fails = 0;
  int   rmode = 0;
  int   rcnt = 0;
  bit   mv = 1'b0;
  logic [7:0] mdata = '0;
  int   taken = 0;

  always #5 clk = ~clk;

  ospi_boot_reader #(.CLK_DIV(DIV), .CNT_W(CNT_W)) u_ospi_boot_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .cs_strap(cs_strap), .busy(busy), .done(done), .sclk(sclk),
    .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic pick_ready();
    rcnt++;
    case (rmode)
      0:       return 1'b1;
      1:       return 1'($urandom_range(0, 1));
      default: return (rcnt % 9) == 8;
    endcase
  endfunction

  function automatic logic [7:0] flash_byte(input int idx, input int run);
    return 8'(8'h5A ^ (idx * 37) ^ (run * 113));
  endfunction

  // One system clock of the reference model: advance, then compare at the negedge.
  task automatic tick(input logic [1:0] ecs, input logic esclk, input logic eoe,
                      input logic ed0, input bit cap, input logic edone,
                      input logic ebusy, input string tag);
    @(posedge clk);
    if (mv && out_ready) begin
      mv = 1'b0;
      taken++;
    end
    if (cap) begin
      mv    = 1'b1;
      mdata = dq_i;
    end
    @(negedge clk);
    start = 1'b0;
    chk(tag, "cs_n", int'(cs_n), int'(ecs));
    chk(tag, "sclk", int'(sclk), int'(esclk));
    chk(tag, "dq_oe", int'(dq_oe), int'({7'b0, eoe}));
    if (eoe) chk(tag, "dq_o[0]", int'(dq_o[0]), int'(ed0));
    chk("R3", "out_valid", int'(out_valid), int'(mv));
    if (mv) chk("R4", "out_data", int'(out_data), int'(mdata));
    chk(tag, "done", int'(done), int'(edone));
    chk(tag, "busy", int'(busy), int'(ebusy));
    out_ready = pick_ready();
  endtask

  task automatic slot(input logic [1:0] ecs, input logic eoe, input logic ed0,
                      input bit clocked, input string tag);
    for (int k = 0; k < DIV; k++)
      tick(ecs, clocked && (k >= HALF), eoe, ed0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic transfer(input int n, input logic strap, input int mode,
                          input int run, input bit poke);
    logic [1:0]  ecs;
    logic [31:0] frame;
    ecs   = strap ? 2'b01 : 2'b10;
    frame = {8'h8B, 24'h000000};
    rmode = mode;
    taken = 0;
    dq_i  = 8'hC3;
    start = 1'b1;
    byte_count = CNT_W'(n);
    cs_strap = strap;
    slot(ecs, 1'b0, 1'b0, 1'b0, "R6");
    for (int b = 31; b >= 0; b--) slot(ecs, 1'b1, frame[b], 1'b1, "R1");
    for (int d = 0; d < 8; d++)   slot(ecs, 1'b0, 1'b0, 1'b1, "R2");
    for (int i = 0; i < n; i++) begin
      if (poke && i == 1) begin
        start = 1'b1;        // R9: must be ignored
        byte_count = CNT_W'(9);
        cs_strap = ~strap;
      end
      tick(ecs, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, poke ? "R9" : "R3");
      while (mv && !out_ready) tick(ecs, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
      dq_i = flash_byte(i, run);
      for (int k = 1; k < DIV; k++)
        tick(ecs, k >= HALF, 1'b0, 1'b0, k == HALF, 1'b0, 1'b1, "R3");
      dq_i = 8'hC3;
    end
    tick(ecs, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    while (mv && !out_ready) tick(ecs, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    for (int k = 1; k < DIV; k++) tick(ecs, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    tick(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    tick(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    chk("R3", "bytes taken", taken, n);
    rmode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "cs_n", int'(cs_n), 3);
    chk("R10", "sclk", int'(sclk), 0);
    chk("R10", "dq_oe", int'(dq_oe), 0);
    chk("R10", "out_valid", int'(out_valid), 0);
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "done", int'(done), 0);

    transfer(3, 1'b0, 0, 1, 1'b0);
    transfer(6, 1'b1, 1, 2, 1'b0);
    transfer(4, 1'b0, 2, 3, 1'b1);

    start = 1'b1;
    byte_count = '0;
    cs_strap = 1'b1;
    tick(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    tick(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");

    transfer(1, 1'b1, 2, 4, 1'b0);
    transfer(5, 1'b0, 1, 5, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule